// File: doc/BRIEF.md
# Cauchy Reed-Solomon 5+3 XOR Encoder

This block is a streaming erasure-code encoder. Five 128-bit data words form one stripe. For each stripe it produces three 128-bit check words. With these check words, any three of the eight words of the stripe can be lost and the stripe can still be rebuilt. The coding matrix is a Cauchy matrix over GF(2^8), expanded into a binary matrix. Because that matrix is fixed when the design is built, the datapath is a constant network of XOR gates with no field multipliers.

Data words arrive on a valid/ready port, one word per accepted beat, and the fifth word of each stripe is marked as the last. Check words leave on a second valid/ready port in a fixed order, with the third one marked as the last. There are two stripe buffers, used alternately. While the check words of one stripe are draining, the next stripe can load into the other buffer. A stripe whose last marker is in the wrong place is reported on a one-cycle error pulse and is discarded.

Top module: `crs_xor_encoder`

## Requirements
- R1: While reset is asserted and immediately after it, `in_ready_o` is 1, `out_valid_o` is 0 and `err_o` is 0.
- R2: A data beat is accepted on a rising clock edge where `in_valid_i` and `in_ready_o` are both 1. The words of a stripe are numbered 0 to 4 in arrival order, and word 4 must carry `in_last_i`=1.
- R3: Each word is split into eight 16-bit packets, where packet c occupies bits [16c+15:16c]. The coefficient for check j (0..2) and data word i (0..4) is e = 1/(j XOR (3+i)) in GF(2^8) with reduction polynomial x^8+x^4+x^3+x^2+1 (0x11D). Packet r of check word j is the XOR of every data packet c of every word i for which bit r of e·x^c is 1.
- R4: The check words of a stripe leave in the order 0, 1, 2, and `out_last_o` is 1 only on check word 2.
- R5: While `out_valid_o` is 1 and `out_ready_i` is 0, `out_valid_o`, `out_data_o` and `out_last_o` hold their values on the next cycle.
- R6: An accepted beat with `in_last_i`=1 at word position 0 to 3 raises `err_o` for exactly the next cycle. The partial stripe is dropped and produces no output, and the next accepted beat is word 0 of a new stripe.
- R7: An accepted word 4 with `in_last_i`=0 raises `err_o` for the next cycle, and the stripe is dropped in the same way.
- R8: `in_ready_o` is 0 exactly when two complete stripes are waiting that have not yet finished output. It returns to 1 in the cycle after the last check word of the older one is accepted.
- R9: Stripes are output in the order in which their fifth word was accepted.
- R10: `out_valid_o` is 1 exactly when at least one complete stripe has not yet finished output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Data word valid |
| in_ready_o | output | 1 | Encoder can accept a data word |
| in_data_i | input | WORD_W | Data word |
| in_last_i | input | 1 | Marks the fifth word of a stripe |
| out_valid_o | output | 1 | Check word valid |
| out_ready_i | input | 1 | Consumer accepts the check word |
| out_data_o | output | WORD_W | Check word |
| out_last_o | output | 1 | Marks check word 2 of a stripe |
| err_o | output | 1 | One-cycle pulse: a stripe had a misplaced last marker and was dropped |

## Verification
The bench compares every check word with a byte-wise GF(2^8) Cauchy model. It uses all-zero, all-one, single-bit and random stripes, so a single wrong coefficient, a wrong packet mapping or a swapped check order shows up as a data mismatch.

It places the last marker early, and it also leaves it off the fifth word. A design that miscounts either case would emit a stripe built from stale or mixed words, or would fail to realign on the next stripe. It would also miss the error pulse or stretch it.

The bench fills both buffers while output is stalled. A design that gets the ping-pong logic wrong would keep `in_ready_o` high and overwrite a pending stripe, or would reopen input a cycle late. It could also drain the stripes out of order.

A long stall and randomly gated `out_ready_i` catch check words that change or skip ahead while they are not being accepted.

// File: rtl/crs_pkg.sv
package crs_pkg;
  localparam int unsigned SYM_W   = 8;
  localparam int unsigned N_DATA  = 5;
  localparam int unsigned N_CHK   = 3;
  localparam int unsigned BM_COLS = N_DATA * SYM_W;
  localparam logic [SYM_W:0] GF_POLY = 9'h11D;

  function automatic logic [SYM_W-1:0] gf_mul(input logic [SYM_W-1:0] a,
                                               input logic [SYM_W-1:0] b);
    logic [SYM_W-1:0] p;
    logic [SYM_W:0]   t;
    p = '0;
    t = {1'b0, a};
    for (int unsigned n = 0; n < SYM_W; n++) begin
      if (b[n]) p ^= t[SYM_W-1:0];
      t = t << 1;
      if (t[SYM_W]) t ^= GF_POLY;
    end
    return p;
  endfunction

  // a^(2^SYM_W - 2) is the inverse of a nonzero element
  function automatic logic [SYM_W-1:0] gf_inv(input logic [SYM_W-1:0] a);
    logic [SYM_W-1:0] res;
    logic [SYM_W-1:0] base;
    res  = SYM_W'(1);
    base = a;
    for (int unsigned n = 1; n < SYM_W; n++) begin
      base = gf_mul(base, base);
      res  = gf_mul(res, base);
    end
    return res;
  endfunction

  // one row of the expanded bit-matrix: check j, packet r
  function automatic logic [BM_COLS-1:0] bm_row(input int unsigned j,
                                                 input int unsigned r);
    logic [BM_COLS-1:0] row;
    logic [SYM_W-1:0]   coef;
    logic [SYM_W-1:0]   prod;
    row = '0;
    for (int unsigned i = 0; i < N_DATA; i++) begin
      coef = gf_inv(SYM_W'(j) ^ SYM_W'(N_CHK + i));
      for (int unsigned c = 0; c < SYM_W; c++) begin
        prod = gf_mul(coef, SYM_W'(1) << c);
        row[i*SYM_W+c] = prod[r];
      end
    end
    return row;
  endfunction
endpackage

// File: rtl/crs_stripe_buf.sv
module crs_stripe_buf #(
  parameter int unsigned WORD_W = 128,
  parameter int unsigned DEPTH  = 5,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic                          clk_i,
  input  logic                          we_i,
  input  logic [AW-1:0]                 addr_i,
  input  logic [WORD_W-1:0]             wdata_i,
  output logic [DEPTH-1:0][WORD_W-1:0]  words_o
);
  logic [DEPTH-1:0][WORD_W-1:0] mem_q;

  // datapath storage, no reset: contents only read once committed
  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
  end

  assign words_o = mem_q;
endmodule

// File: rtl/crs_xor_net.sv
module crs_xor_net
  import crs_pkg::*;
#(
  parameter int unsigned WORD_W = 128,
  localparam int unsigned PKT_W = WORD_W / SYM_W
) (
  input  logic [N_DATA-1:0][WORD_W-1:0] data_i,
  output logic [N_CHK-1:0][WORD_W-1:0]  chk_o
);
  logic [BM_COLS-1:0][PKT_W-1:0] pkt;

  for (genvar i = 0; i < N_DATA; i++) begin : g_word
    for (genvar c = 0; c < SYM_W; c++) begin : g_pkt
      assign pkt[i*SYM_W+c] = data_i[i][c*PKT_W +: PKT_W];
    end
  end

  for (genvar j = 0; j < N_CHK; j++) begin : g_chk
    for (genvar r = 0; r < SYM_W; r++) begin : g_row
      localparam logic [BM_COLS-1:0] ROW = bm_row(j, r);
      logic [PKT_W-1:0] acc;
      // ROW is constant: the loop folds into a fixed XOR tree
      always_comb begin
        acc = '0;
        for (int unsigned n = 0; n < BM_COLS; n++) begin
          if (ROW[n]) acc ^= pkt[n];
        end
      end
      assign chk_o[j][r*PKT_W +: PKT_W] = acc;
    end
  end
endmodule

// File: rtl/crs_wr_ctrl.sv
module crs_wr_ctrl #(
  parameter int unsigned N_WORDS = 5,
  localparam int unsigned CNT_W  = $clog2(N_WORDS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  input  logic             in_last_i,
  input  logic [1:0]       full_i,
  output logic             in_ready_o,
  output logic             wr_en_o,
  output logic             wr_sel_o,
  output logic [CNT_W-1:0] wr_addr_o,
  output logic             commit_o,
  output logic             err_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             sel_q;
  logic             err_q;
  logic             beat;
  logic             at_end;
  logic             bad;

  assign in_ready_o = ~full_i[sel_q];
  assign beat       = in_valid_i & in_ready_o;
  assign at_end     = (cnt_q == CNT_W'(N_WORDS - 1));
  assign bad        = beat & (in_last_i != at_end);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sel_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      err_q <= bad;
      if (beat) begin
        if (bad) begin
          cnt_q <= '0;
        end else if (at_end) begin
          cnt_q <= '0;
          sel_q <= ~sel_q;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign wr_en_o   = beat;
  assign wr_sel_o  = sel_q;
  assign wr_addr_o = cnt_q;
  assign commit_o  = beat & at_end & in_last_i;
  assign err_o     = err_q;
endmodule

// File: rtl/crs_rd_ctrl.sv
module crs_rd_ctrl #(
  parameter int unsigned N_OUT = 3,
  localparam int unsigned IDX_W = $clog2(N_OUT)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             commit_i,
  input  logic             commit_sel_i,
  input  logic             out_ready_i,
  output logic             out_valid_o,
  output logic             out_last_o,
  output logic             rd_sel_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [1:0]       full_o
);
  logic [1:0]       full_q, full_d;
  logic             sel_q;
  logic [IDX_W-1:0] idx_q;
  logic             hs;

  assign out_valid_o = full_q[sel_q];
  assign out_last_o  = (idx_q == IDX_W'(N_OUT - 1));
  assign hs          = out_valid_o & out_ready_i;

  always_comb begin
    full_d = full_q;
    if (commit_i)         full_d[commit_sel_i] = 1'b1;
    if (hs && out_last_o) full_d[sel_q]        = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= '0;
      sel_q  <= 1'b0;
      idx_q  <= '0;
    end else begin
      full_q <= full_d;
      if (hs) begin
        if (out_last_o) begin
          idx_q <= '0;
          sel_q <= ~sel_q;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  assign rd_sel_o = sel_q;
  assign idx_o    = idx_q;
  assign full_o   = full_q;
endmodule

// File: rtl/crs_xor_encoder.sv
module crs_xor_encoder
  import crs_pkg::*;
#(
  parameter int unsigned WORD_W = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [WORD_W-1:0] in_data_i,
  input  logic              in_last_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [WORD_W-1:0] out_data_o,
  output logic              out_last_o,
  output logic              err_o
);
  localparam int unsigned AW    = $clog2(N_DATA);
  localparam int unsigned IDX_W = $clog2(N_CHK);

  logic                                 wr_en, wr_sel, commit;
  logic [AW-1:0]                        wr_addr;
  logic [1:0]                           full;
  logic                                 rd_sel;
  logic [IDX_W-1:0]                     out_idx;
  logic [1:0][N_DATA-1:0][WORD_W-1:0]   buf_words;
  logic [N_DATA-1:0][WORD_W-1:0]        rd_words;
  logic [N_CHK-1:0][WORD_W-1:0]         chk_words;

  crs_wr_ctrl #(.N_WORDS(N_DATA)) u_wr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_valid_i (in_valid_i),
    .in_last_i  (in_last_i),
    .full_i     (full),
    .in_ready_o (in_ready_o),
    .wr_en_o    (wr_en),
    .wr_sel_o   (wr_sel),
    .wr_addr_o  (wr_addr),
    .commit_o   (commit),
    .err_o      (err_o)
  );

  for (genvar b = 0; b < 2; b++) begin : g_buf
    crs_stripe_buf #(.WORD_W(WORD_W), .DEPTH(N_DATA)) u_buf (
      .clk_i   (clk_i),
      .we_i    (wr_en && (wr_sel == 1'(b))),
      .addr_i  (wr_addr),
      .wdata_i (in_data_i),
      .words_o (buf_words[b])
    );
  end

  assign rd_words = buf_words[rd_sel];

  crs_xor_net #(.WORD_W(WORD_W)) u_net (
    .data_i (rd_words),
    .chk_o  (chk_words)
  );

  crs_rd_ctrl #(.N_OUT(N_CHK)) u_rd (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .commit_i     (commit),
    .commit_sel_i (wr_sel),
    .out_ready_i  (out_ready_i),
    .out_valid_o  (out_valid_o),
    .out_last_o   (out_last_o),
    .rd_sel_o     (rd_sel),
    .idx_o        (out_idx),
    .full_o       (full)
  );

  assign out_data_o = chk_words[out_idx];
endmodule

// File: rtl/crs_xor_encoder_chk.sv
module crs_xor_encoder_chk #(
  parameter int unsigned WORD_W = 128
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_valid_i,
  input logic              in_ready_o,
  input logic              in_last_i,
  input logic              out_valid_o,
  input logic              out_ready_i,
  input logic [WORD_W-1:0] out_data_o,
  input logic              out_last_o,
  input logic              err_o
);
  logic [2:0] icnt_q;
  logic [1:0] pend_q;
  logic [1:0] ocnt_q;
  logic       err_exp_q;
  logic       in_hs, out_hs, mism, good;

  assign in_hs  = in_valid_i & in_ready_o;
  assign out_hs = out_valid_o & out_ready_i;
  assign mism   = in_hs & (in_last_i != (icnt_q == 3'd4));
  assign good   = in_hs & in_last_i & (icnt_q == 3'd4);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      icnt_q    <= '0;
      pend_q    <= '0;
      ocnt_q    <= '0;
      err_exp_q <= 1'b0;
    end else begin
      err_exp_q <= mism;
      if (in_hs) icnt_q <= (mism || icnt_q == 3'd4) ? 3'd0 : icnt_q + 3'd1;
      if (out_hs) ocnt_q <= (ocnt_q == 2'd2) ? 2'd0 : ocnt_q + 2'd1;
      pend_q <= pend_q + {1'b0, good} - {1'b0, out_hs && out_last_o};
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_state_r1: assert (in_ready_o && !out_valid_o && !err_o)
        else $error("reset state");
    end
  end

  p_order_last_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (out_last_o == (ocnt_q == 2'd2)));

  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=>
      (out_valid_o && $stable(out_data_o) && $stable(out_last_o)));

  // R6 and R7: misplaced last marker pulses err_o
  p_err_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o == err_exp_q);

  p_ready_full_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!in_ready_o) == (pend_q == 2'd2));

  p_no_overflow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q != 2'd3);

  p_valid_pending_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o == (pend_q != 2'd0));
endmodule

bind crs_xor_encoder crs_xor_encoder_chk #(.WORD_W(WORD_W)) u_chk (.*);

// File: tb/crs_xor_encoder_bench.sv
`timescale 1ns/1ps
module crs_xor_encoder_bench;
  localparam int W = 128;
  typedef logic [4:0][W-1:0] stripe_t;
  typedef logic [2:0][W-1:0] chk_t;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b1;
  logic in_valid_i = 1'b0;
  logic in_last_i = 1'b0;
  logic [W-1:0] in_data_i = '0;
  logic out_ready_i = 1'b0;
  logic in_ready_o, out_valid_o, out_last_o, err_o;
  logic [W-1:0] out_data_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk_i = ~clk_i;

  crs_xor_encoder #(.WORD_W(W)) u_crs_xor_encoder (
    .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .in_ready_o(in_ready_o),
    .in_data_i(in_data_i), .in_last_i(in_last_i), .out_valid_o(out_valid_o),
    .out_ready_i(out_ready_i), .out_data_o(out_data_o), .out_last_o(out_last_o),
    .err_o(err_o)
  );

  // behavioural GF(2^8) model, byte-wise across packets
  function automatic logic [7:0] m_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p = 8'd0;
    logic [7:0] x = a;
    for (int n = 0; n < 8; n++) begin
      if (b[n]) p ^= x;
      x = x[7] ? ((x << 1) ^ 8'h1D) : (x << 1);
    end
    return p;
  endfunction

  function automatic logic [7:0] m_inv(input logic [7:0] a);
    for (int n = 1; n < 256; n++)
      if (m_mul(a, 8'(n)) == 8'd1) return 8'(n);
    return 8'd0;
  endfunction

  function automatic chk_t m_encode(input stripe_t d);
    chk_t c = '0;
    for (int j = 0; j < 3; j++)
      for (int b = 0; b < 16; b++) begin
        logic [7:0] acc = 8'd0;
        for (int i = 0; i < 5; i++) begin
          logic [7:0] sym;
          for (int p = 0; p < 8; p++) sym[p] = d[i][p*16+b];
          acc ^= m_mul(m_inv(8'(j) ^ 8'(3 + i)), sym);
        end
        for (int r = 0; r < 8; r++) c[j][r*16+b] = acc[r];
      end
    return c;
  endfunction

  function automatic stripe_t rnd_stripe();
    stripe_t s;
    for (int i = 0; i < 5; i++) s[i] = {$urandom, $urandom, $urandom, $urandom};
    return s;
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic put_word(input logic [W-1:0] d, input logic last);
    logic acc;
    in_data_i = d;
    in_last_i = last;
    in_valid_i = 1'b1;
    do begin
      acc = in_ready_o;
      @(posedge clk_i); #1;
    end while (!acc);
    in_valid_i = 1'b0;
    in_last_i = 1'b0;
  endtask

  task automatic put_stripe(input stripe_t s);
    for (int i = 0; i < 5; i++) put_word(s[i], i == 4);
  endtask

  task automatic get_stripe(input chk_t e, input string req);
    out_ready_i = 1'b1;
    for (int j = 0; j < 3; j++) begin
      while (!out_valid_o) begin @(posedge clk_i); #1; end
      chk({req, " R3 data"}, out_data_o, e[j]);
      chk("R4 out_last position", W'(out_last_o), W'(j == 2));
      @(posedge clk_i); #1;
    end
    out_ready_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 in_ready in reset", W'(in_ready_o), W'(1));
    chk("R1 out_valid in reset", W'(out_valid_o), W'(0));
    chk("R1 err in reset", W'(err_o), W'(0));
    rst_ni = 1'b1;
    @(posedge clk_i); #1;
    chk("R1 out_valid after reset", W'(out_valid_o), W'(0));
    chk("R1 in_ready after reset", W'(in_ready_o), W'(1));
  endtask

  task automatic t_patterns();
    stripe_t s;
    s = '0;
    put_stripe(s); get_stripe(m_encode(s), "R2 zero stripe");
    s = '1;
    put_stripe(s); get_stripe(m_encode(s), "R2 ones stripe");
    for (int i = 0; i < 5; i++) s[i] = W'(1) << (i * 27 + 5);
    put_stripe(s); get_stripe(m_encode(s), "R2 sparse bits");
    s = '0; s[4][W-1] = 1'b1;
    put_stripe(s); get_stripe(m_encode(s), "R2 single top bit");
    s = rnd_stripe();
    put_stripe(s); get_stripe(m_encode(s), "R2 random");
  endtask

  task automatic t_hold();
    stripe_t s = rnd_stripe();
    chk_t e = m_encode(s);
    out_ready_i = 1'b0;
    put_stripe(s);
    for (int k = 0; k < 4; k++) begin
      chk("R5 valid held", W'(out_valid_o), W'(1));
      chk("R5 data held", out_data_o, e[0]);
      chk("R5 last held", W'(out_last_o), W'(0));
      @(posedge clk_i); #1;
    end
    get_stripe(e, "R5 after stall");
  endtask

  task automatic t_early_last();
    stripe_t s = rnd_stripe();
    put_word(s[0], 1'b0);
    put_word(s[1], 1'b1);
    chk("R6 err pulse", W'(err_o), W'(1));
    @(posedge clk_i); #1;
    chk("R6 err one cycle", W'(err_o), W'(0));
    chk("R6 dropped, no output", W'(out_valid_o), W'(0));
    put_word(s[0], 1'b1);
    chk("R6 last on word 0", W'(err_o), W'(1));
    s = rnd_stripe();
    put_stripe(s);
    chk("R6 realigned no err", W'(err_o), W'(0));
    get_stripe(m_encode(s), "R6 realigned stripe");
  endtask

  task automatic t_missing_last();
    stripe_t s = rnd_stripe();
    for (int i = 0; i < 5; i++) put_word(s[i], 1'b0);
    chk("R7 err on fifth", W'(err_o), W'(1));
    @(posedge clk_i); #1;
    chk("R7 dropped, no output", W'(out_valid_o), W'(0));
    chk("R7 err cleared", W'(err_o), W'(0));
    s = rnd_stripe();
    put_stripe(s);
    get_stripe(m_encode(s), "R7 next stripe");
  endtask

  task automatic t_pingpong();
    stripe_t a = rnd_stripe();
    stripe_t b = rnd_stripe();
    out_ready_i = 1'b0;
    put_stripe(a);
    chk("R8 ready with one pending", W'(in_ready_o), W'(1));
    chk("R10 valid with one pending", W'(out_valid_o), W'(1));
    put_stripe(b);
    chk("R8 not ready with two pending", W'(in_ready_o), W'(0));
    @(posedge clk_i); #1;
    chk("R8 stays not ready", W'(in_ready_o), W'(0));
    get_stripe(m_encode(a), "R9 first stripe");
    chk("R8 ready after drain", W'(in_ready_o), W'(1));
    get_stripe(m_encode(b), "R9 second stripe");
    chk("R10 idle after drain", W'(out_valid_o), W'(0));
  endtask

  task automatic t_stream();
    stripe_t s[6];
    chk_t e[6];
    for (int n = 0; n < 6; n++) begin s[n] = rnd_stripe(); e[n] = m_encode(s[n]); end
    fork
      for (int n = 0; n < 6; n++) put_stripe(s[n]);
      for (int n = 0; n < 6; n++)
        for (int j = 0; j < 3; j++) begin
          logic hs;
          do begin
            out_ready_i = 1'($urandom % 2);
            hs = out_valid_o && out_ready_i;
            if (hs) begin
              chk("R9 R3 streamed data", out_data_o, e[n][j]);
              chk("R4 streamed last", W'(out_last_o), W'(j == 2));
            end
            @(posedge clk_i); #1;
          end while (!hs);
        end
    join
    out_ready_i = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #1 rst_ni = 1'b0;
    repeat (3) @(posedge clk_i);
    #1;
    t_reset();
    t_patterns();
    t_hold();
    t_early_last();
    t_missing_last();
    t_pingpong();
    t_stream();
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog (all requirements): actual hung expected done");
    summary();
    $finish;
  end
endmodule